// File: doc/BRIEF.md
# Two-Context Reconfiguration Load Controller

This controller sits between a system bus and a reconfigurable region that can hold one of two configuration contexts at a time. Four function slots share the region. Slots 0, 1 and 2 belong to the first context and slot 3 belongs to the second. The controller records which context is resident. When a bus request names a slot whose context is already loaded, the request is granted at once. When the slot belongs to the other context, the request is held while the whole image of the needed context is streamed out of a configuration memory. The grant is given only after the last word has left the block.

Each context has a fixed start address and a fixed length in the configuration memory, and both are parameters. Reads are paced by a clock-enable divider, so one 16-bit word moves per enable pulse at a fraction of the system clock rate. No read is ever issued past the last address of the configuration window. An image that would run past that address is cut short at elaboration time.

A status group reports three things: the resident context, a busy flag, and a wrapping count of completed loads.

Top module: `ctx_load_ctrl`

## Requirements
- R1: Slot codes 0, 1 and 2 select the first context, and slot code 3 selects the second. `stat_resident` encodes 0 for no context, 1 for the first context and 2 for the second.
- R2: After reset, `stat_resident` is 0, `stat_busy` is 0, `stat_reloads` is 0, `req_grant` is 0, and neither `cfg_rd_en` nor `cfg_out_valid` is high.
- R3: A request whose slot is in the resident context is granted in the cycle after the request is sampled, and it causes no configuration read.
- R4: A request whose slot is in the other context starts a load. The load reads addresses from the context's base upward, one address per read, with at most one read per `CLK_DIV` cycles. The first read comes `CLK_DIV`-1 cycles after the load begins.
- R5: No read address exceeds `MEM_END`. An image reaching past it is shortened to end exactly at `MEM_END`.
- R6: The memory word returned for each read appears on `cfg_out_data` with `cfg_out_valid` high two cycles after that read, in read order.
- R7: `req_grant` rises one cycle after the last word of a load is output. A miss of N words is therefore granted N*`CLK_DIV`+3 clock edges after the request is first sampled.
- R8: During a load, `stat_busy` is 1 and `stat_resident` reads 0. When the load ends, `stat_resident` takes the loaded context and `stat_reloads` increases by exactly one.
- R9: At the end of a load, the request is evaluated again using its current slot. A slot in the loaded context is granted. A slot in the other context starts the next load in the following cycle.
- R10: A request withdrawn during a load does not stop the load. The load runs to completion, no grant is given, and the block returns to idle.
- R11: `req_grant` is a single-cycle pulse. A requester drops `req_valid` after seeing it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Bus request pending, held until granted |
| req_slot | input | 2 | Function slot targeted by the request |
| req_grant | output | 1 | One-cycle acceptance of the request |
| cfg_rd_en | output | 1 | Configuration memory read strobe |
| cfg_addr | output | ADDR_W | Configuration memory read address |
| cfg_rd_data | input | DATA_W | Read data, valid one cycle after the strobe |
| cfg_out_valid | output | 1 | Configuration word valid toward the region |
| cfg_out_data | output | DATA_W | Configuration word toward the region |
| stat_resident | output | 2 | Resident context (0 none, 1 first, 2 second) |
| stat_busy | output | 1 | A load is in progress |
| stat_reloads | output | CNT_W | Completed loads, wrapping |

## Verification
The end of one load and the decision on a new request fall in the same cycle. In that cycle the block marks the finished context resident and, at the same moment, judges the current request against that context. The bench provokes this by changing the slot to the opposite context part way through a load. It then checks the total grant latency of two back-to-back loads, the read count across both loads, the final resident context, and that the reload count rose by two. A withdrawn request tests the same cycle from the other side: the load must finish and set the resident context, and no grant may appear.

// File: rtl/ctx_load_pkg.sv
package ctx_load_pkg;

    localparam int SLOT_W = 2;

    typedef enum logic [1:0] {
        CTX_NONE = 2'd0,
        CTX_ONE  = 2'd1,
        CTX_TWO  = 2'd2
    } ctx_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_FLUSH,
        ST_FINAL,
        ST_GRANT
    } ld_state_e;

    typedef struct packed {
        logic go;
        logic hit;
        ctx_e want;
    } decision_t;

    // slot 3 is the estimator slot in the second context, the rest share the first
    function automatic ctx_e slot_ctx(input logic [SLOT_W-1:0] slot);
        return (slot == 2'd3) ? CTX_TWO : CTX_ONE;
    endfunction

    function automatic decision_t decide(input logic valid,
                                         input logic [SLOT_W-1:0] slot,
                                         input ctx_e have);
        decision_t d;
        d.go   = valid;
        d.want = slot_ctx(slot);
        d.hit  = valid && (d.want == have);
        return d;
    endfunction

    // words of an image that fit at or below the last window address
    function automatic int clip_len(input int base, input int len, input int last_addr);
        if (base > last_addr) return 0;
        if (base + len - 1 > last_addr) return last_addr - base + 1;
        return len;
    endfunction

endpackage

// File: rtl/ctx_clk_div.sv
module ctx_clk_div #(
    parameter int DIV = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    output logic en
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (cnt == CW'(DIV - 1)) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end

    assign en = (cnt == CW'(DIV - 1));

endmodule

// File: rtl/ctx_addr_gen.sv
module ctx_addr_gen #(
    parameter int ADDR_W = 18,
    parameter int LEN_W  = 17
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_base,
    input  logic [LEN_W-1:0]  start_len,
    input  logic              step,
    output logic              rd_en,
    output logic [ADDR_W-1:0] addr,
    output logic              last
);
    logic [LEN_W-1:0] left;

    assign rd_en = step && (left != '0);
    assign last  = rd_en && (left == LEN_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            addr <= '0;
            left <= '0;
        end else if (start) begin
            addr <= start_base;
            left <= start_len;
        end else if (rd_en) begin
            addr <= addr + ADDR_W'(1);
            left <= left - LEN_W'(1);
        end
    end

    // R4: addresses climb by one per issued read
    a_r4_addr_climbs: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !start) |=> (addr == $past(addr) + ADDR_W'(1)));

endmodule

// File: rtl/ctx_out_stage.sv
module ctx_out_stage #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] rd_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    logic rd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q      <= 1'b0;
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            rd_q      <= rd_en;
            out_valid <= rd_q;
            if (rd_q) out_data <= rd_data;
        end
    end

    // R6: every output word traces back to a read two cycles earlier
    a_r6_valid_after_read: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(rd_en, 2));

endmodule

// File: rtl/ctx_load_ctrl.sv
module ctx_load_ctrl
    import ctx_load_pkg::*;
#(
    parameter int CTX1_BASE = 0,
    parameter int CTX1_LEN  = 76754,
    parameter int CTX2_BASE = 76755,
    parameter int CTX2_LEN  = 101158,
    parameter int MEM_END   = 180000,
    parameter int CLK_DIV   = 3,
    parameter int DATA_W    = 16,
    parameter int CNT_W     = 16,
    parameter int ADDR_W    = $clog2(MEM_END + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [1:0]        req_slot,
    output logic              req_grant,
    output logic              cfg_rd_en,
    output logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_rd_data,
    output logic              cfg_out_valid,
    output logic [DATA_W-1:0] cfg_out_data,
    output logic [1:0]        stat_resident,
    output logic              stat_busy,
    output logic [CNT_W-1:0]  stat_reloads
);
    localparam int EFF1   = clip_len(CTX1_BASE, CTX1_LEN, MEM_END);
    localparam int EFF2   = clip_len(CTX2_BASE, CTX2_LEN, MEM_END);
    localparam int MAXLEN = (EFF1 > EFF2) ? EFF1 : EFF2;
    localparam int LEN_W  = $clog2(MAXLEN + 1);

    // per-context image table
    logic [ADDR_W-1:0] base_tab [2];
    logic [LEN_W-1:0]  len_tab  [2];

    for (genvar g = 0; g < 2; g++) begin : g_tab
        if (g == 0) begin : g_first
            assign base_tab[g] = ADDR_W'(CTX1_BASE);
            assign len_tab[g]  = LEN_W'(EFF1);
        end else begin : g_second
            assign base_tab[g] = ADDR_W'(CTX2_BASE);
            assign len_tab[g]  = LEN_W'(EFF2);
        end
    end

    ld_state_e        state, nxt;
    ctx_e             resident, tgt, have;
    decision_t        dec;
    logic             eval, start_load, div_en, step, last;
    logic             sel;
    logic [CNT_W-1:0] reloads;

    // at the end of a load the request is judged against the context just written
    assign have       = (state == ST_FINAL) ? tgt : resident;
    assign dec        = decide(req_valid, req_slot, have);
    assign eval       = (state == ST_IDLE) || (state == ST_FINAL);
    assign start_load = eval && dec.go && !dec.hit;
    assign sel        = (dec.want == CTX_TWO);
    assign step       = (state == ST_LOAD) && div_en;

    ctx_clk_div #(.DIV(CLK_DIV)) u_div (
        .clk (clk),
        .rst (rst),
        .clr (start_load),
        .en  (div_en)
    );

    ctx_addr_gen #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_addr (
        .clk        (clk),
        .rst        (rst),
        .start      (start_load),
        .start_base (base_tab[sel]),
        .start_len  (len_tab[sel]),
        .step       (step),
        .rd_en      (cfg_rd_en),
        .addr       (cfg_addr),
        .last       (last)
    );

    ctx_out_stage #(.DATA_W(DATA_W)) u_out (
        .clk       (clk),
        .rst       (rst),
        .rd_en     (cfg_rd_en),
        .rd_data   (cfg_rd_data),
        .out_valid (cfg_out_valid),
        .out_data  (cfg_out_data)
    );

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE, ST_FINAL: begin
                if (start_load)          nxt = ST_LOAD;
                else if (dec.hit)        nxt = ST_GRANT;
                else                     nxt = ST_IDLE;
            end
            ST_LOAD:  if (last) nxt = ST_FLUSH;
            ST_FLUSH: nxt = ST_FINAL;
            ST_GRANT: nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            resident <= CTX_NONE;
            tgt      <= CTX_NONE;
            reloads  <= '0;
        end else begin
            state <= nxt;
            if (start_load) tgt <= dec.want;
            if (start_load)               resident <= CTX_NONE;
            else if (state == ST_FINAL)   resident <= tgt;
            if (state == ST_FINAL)        reloads  <= reloads + CNT_W'(1);
        end
    end

    assign req_grant     = (state == ST_GRANT);
    assign stat_busy     = (state == ST_LOAD) || (state == ST_FLUSH) || (state == ST_FINAL);
    assign stat_resident = resident;
    assign stat_reloads  = reloads;

    // R11: grant never lasts two cycles
    a_r11_grant_pulse: assert property (@(posedge clk) disable iff (rst)
        req_grant |=> !req_grant);

    // R3: a grant answers a request seen the cycle before, without reading
    a_r3_grant_from_req: assert property (@(posedge clk) disable iff (rst)
        req_grant |-> ($past(req_valid) && !cfg_rd_en));

    // R5: reads stay inside the configuration window
    a_r5_in_window: assert property (@(posedge clk) disable iff (rst)
        cfg_rd_en |-> (cfg_addr <= ADDR_W'(MEM_END)));

    // R8: a loading region has no resident context
    a_r8_busy_no_resident: assert property (@(posedge clk) disable iff (rst)
        stat_busy |-> (stat_resident == 2'd0));

    // R8: the reload count moves by one, only when a load closes
    a_r8_count_step: assert property (@(posedge clk) disable iff (rst)
        (stat_reloads != $past(stat_reloads)) |->
            ($past(state) == ST_FINAL && stat_reloads == $past(stat_reloads) + CNT_W'(1)));

    // R4: reads are spaced by the divider
    if (CLK_DIV > 1) begin : g_rate_chk
        a_r4_read_rate: assert property (@(posedge clk) disable iff (rst)
            cfg_rd_en |=> !cfg_rd_en);
    end

endmodule

// File: tb/tb_ctx_load_ctrl.sv
module tb_ctx_load_ctrl;

    localparam int B1 = 0, L1 = 5, B2 = 5, L2 = 7, WEND = 10, DIV = 3;
    localparam int AW = $clog2(WEND + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic [1:0]    req_slot = 2'd0;
    logic          req_grant, cfg_rd_en, cfg_out_valid, stat_busy;
    logic [AW-1:0] cfg_addr;
    logic [15:0]   cfg_rd_data, cfg_out_data;
    logic [1:0]    stat_resident;
    logic [15:0]   stat_reloads;

    int checks = 0, errors = 0;
    int res_m = 0, cnt_m = 0;

    // observation results of the last request
    int got, wait_n, rd_n, first_n, first_a, last_a, out_n, bad_data, bad_gap, bad_win;
    int mid_busy, mid_res;

    always #5 clk = ~clk;

    ctx_load_ctrl #(
        .CTX1_BASE(B1), .CTX1_LEN(L1), .CTX2_BASE(B2), .CTX2_LEN(L2),
        .MEM_END(WEND), .CLK_DIV(DIV), .DATA_W(16), .CNT_W(16)
    ) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_slot(req_slot),
        .req_grant(req_grant), .cfg_rd_en(cfg_rd_en), .cfg_addr(cfg_addr),
        .cfg_rd_data(cfg_rd_data), .cfg_out_valid(cfg_out_valid),
        .cfg_out_data(cfg_out_data), .stat_resident(stat_resident),
        .stat_busy(stat_busy), .stat_reloads(stat_reloads)
    );

    function automatic logic [15:0] pat(input int a);
        return 16'((a * 41) ^ 23100);
    endfunction

    // configuration memory, one cycle read latency
    always @(posedge clk) if (cfg_rd_en) cfg_rd_data <= pat(int'(cfg_addr));

    function automatic int eff_len(input int c);
        int b, l;
        b = (c == 2) ? B2 : B1;
        l = (c == 2) ? L2 : L1;
        return (b + l - 1 > WEND) ? WEND - b + 1 : l;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    // drive a request and watch every cycle until grant or limit
    task automatic watch(input logic [1:0] slot, input int sw_at, input logic [1:0] slot_b,
                         input int drop_at, input int limit);
        int h1, h2, last_rd;
        got = 0; wait_n = 0; rd_n = 0; first_n = -1; first_a = -1; last_a = -1;
        out_n = 0; bad_data = 0; bad_gap = 0; bad_win = 0; mid_busy = -1; mid_res = -1;
        h1 = -1; h2 = -1; last_rd = -100;
        req_slot  = slot;
        req_valid = 1'b1;
        for (int n = 1; n <= limit; n++) begin
            @(negedge clk);
            if (cfg_out_valid) begin
                out_n++;
                if (h2 < 0 || cfg_out_data != pat(h2)) bad_data++;
            end
            h2 = h1;
            h1 = -1;
            if (cfg_rd_en) begin
                if (n - last_rd < DIV) bad_gap++;
                last_rd = n;
                if (first_n < 0) begin first_n = n; first_a = int'(cfg_addr); end
                last_a = int'(cfg_addr);
                if (int'(cfg_addr) > WEND) bad_win++;
                h1 = int'(cfg_addr);
                rd_n++;
            end
            if (n == 2) begin mid_busy = int'(stat_busy); mid_res = int'(stat_resident); end
            if (n == sw_at) req_slot = slot_b;
            if (n == drop_at) req_valid = 1'b0;
            if (req_grant) begin
                got = 1; wait_n = n; req_valid = 1'b0;
                break;
            end
        end
        req_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic check_status(input string tag);
        chk({tag, " R8 resident"}, int'(stat_resident), res_m);
        chk({tag, " R8 reloads"}, int'(stat_reloads), cnt_m);
        chk({tag, " R8 idle busy"}, int'(stat_busy), 0);
    endtask

    // plain access with the expected outcome computed from the model
    task automatic access(input logic [1:0] slot);
        int c, w, b;
        c = (slot == 2'd3) ? 2 : 1;
        watch(slot, 0, slot, 0, 400);
        chk("R11 granted", got, 1);
        if (c == res_m) begin
            chk("R3 hit latency", wait_n, 1);
            chk("R3 hit no reads", rd_n, 0);
        end else begin
            w = eff_len(c);
            b = (c == 2) ? B2 : B1;
            chk("R1 R4 words read", rd_n, w);
            chk("R4 first address", first_a, b);
            chk("R5 last address", last_a, b + w - 1);
            chk("R4 first read cycle", first_n, DIV);
            chk("R4 read spacing", bad_gap, 0);
            chk("R5 window", bad_win, 0);
            chk("R6 words out", out_n, w);
            chk("R6 data order", bad_data, 0);
            chk("R7 miss latency", wait_n, w * DIV + 3);
            chk("R8 busy mid load", mid_busy, 1);
            chk("R8 resident mid load", mid_res, 0);
            res_m = c;
            cnt_m++;
        end
        check_status("access");
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R2 reset state
        chk("R2 resident", int'(stat_resident), 0);
        chk("R2 busy", int'(stat_busy), 0);
        chk("R2 reloads", int'(stat_reloads), 0);
        chk("R2 grant", int'(req_grant), 0);
        chk("R2 read", int'(cfg_rd_en), 0);
        chk("R2 out valid", int'(cfg_out_valid), 0);

        // sweep over every ordered pair of slots
        for (int p = 0; p < 4; p++)
            for (int q = 0; q < 4; q++) begin
                access(2'(p));
                access(2'(q));
            end

        // R9: slot changed mid load to the other context; two loads, one grant
        if (res_m != 1) access(2'd0);
        watch(2'd3, 5, 2'd1, 0, 400);
        chk("R9 granted", got, 1);
        chk("R9 latency", wait_n, eff_len(2) * DIV + 2 + eff_len(1) * DIV + 2 + 1);
        chk("R9 reads", rd_n, eff_len(2) + eff_len(1));
        chk("R9 words out", out_n, eff_len(2) + eff_len(1));
        chk("R9 data order", bad_data, 0);
        res_m = 1; cnt_m += 2;
        check_status("R9");

        // R9: slot changed mid load within the loading context; grant right after
        watch(2'd3, 4, 2'd3, 0, 400);
        chk("R9 same ctx latency", wait_n, eff_len(2) * DIV + 3);
        res_m = 2; cnt_m++;
        check_status("R9 same");

        // R10: request withdrawn during a load
        watch(2'd2, 0, 2'd2, 4, 40);
        chk("R10 no grant", got, 0);
        chk("R10 load completed reads", rd_n, eff_len(1));
        res_m = 1; cnt_m++;
        check_status("R10");
        chk("R10 stays idle grant", int'(req_grant), 0);

        // R3 after R10: the withdrawn slot's context is now resident
        access(2'd1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule